// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This unit sits between the software register port of an SPI controller and its serial shift engine. It holds a transmit FIFO that software fills and the engine drains, and a receive FIFO that the engine fills and software drains. Around the two queues it keeps programmable watermarks, a status word that mixes live level flags with sticky event flags, an interrupt-enable word laid out on the same bit positions, and one level interrupt.

Software reaches the unit through a simple single-cycle register port. A write strobe with an address stores or acts at the next clock edge. Read data is combinational from the address. A read strobe on the receive-data address also pops the receive FIFO at that edge. The engine side offers the head transmit word with an availability flag. It also takes a word-consumed strobe, a word-received strobe with its data, a frame-end pulse, a transfer-end pulse and a busy level. An enumerated register-select type decodes the address into one of nine selections (`SEL_PARAM`, `SEL_CTRL`, `SEL_STAT`, `SEL_IEN`, `SEL_WMARK`, `SEL_FSTAT`, `SEL_TXDATA`, `SEL_RXSTAT`, `SEL_RXDATA`) or `SEL_NONE`.

Top module: `spi_fifo_stat`

## Requirements
- R1: After reset both FIFOs are empty and the following hold. The parameter word (offset 0x00) reads transmit log2 depth in bits 3:0 and receive log2 depth in bits 11:8, which is 0x202 by default. The status word (0x08) reads 0x1. The FIFO-status word (0x14) reads 0. The interrupt output is low.
- R2: A write to 0x18 queues a transmit word. The engine sees the oldest word on `eng_tx_data`, and each word-consumed strobe removes one word, so words leave in write order. A word-received strobe queues `eng_rx_data`, but it is dropped if the receive FIFO is full. Offset 0x14 reports the transmit count in bits 7:0 and the receive count in bits 18:16.
- R3: A write to 0x18 while the transmit FIFO is full leaves the FIFO contents and count unchanged. It also sets the sticky status bit 11.
- R4: A read strobe at 0x20 returns the oldest receive word and removes it. When the receive FIFO is empty, such a read returns 0, leaves the count at 0 and sets the sticky status bit 12. Bit 1 of 0x1C reads 1 exactly when the receive FIFO is empty.
- R5: The watermark word (0x10) holds the transmit watermark in its low field and the receive watermark from bit 16. Status bit 0 is 1 while the transmit count is at or below the transmit watermark. Status bit 1 is 1 while the receive count is above the receive watermark.
- R6: Enabled frame-end and transfer-end pulses set status bits 9 and 10. These bits stay set until cleared. Writing 0 to them has no effect, and a pulse arriving in the same cycle as a clearing write leaves the bit set.
- R7: Writing 1 to any of status bits 13:8 clears that event bit. Writing 0x3F00 clears all of them.
- R8: Status bit 24 follows the engine busy level.
- R9: The enable word (0x0C) keeps only bits 0, 1, 9, 10, 11 and 12, so it reads 0x1E03 after writing all ones. The interrupt output is high when any status bit is set together with its enable bit.
- R10: Writing control (0x04) with bit 8 set empties the transmit FIFO, and with bit 9 set empties the receive FIFO. The other FIFO is left untouched.
- R11: Writing control with bit 1 set returns every register and both FIFOs to their reset values, whatever else the same write carries.
- R12: Control bit 0 is the module enable and reads back. While it is 0, the word-consumed, word-received, frame-end and transfer-end inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at receive-data address) |
| reg_addr | input | 6 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| eng_tx_data | output | 32 | Oldest transmit word |
| eng_tx_avail | output | 1 | Transmit FIFO not empty |
| eng_pop | input | 1 | Engine consumed one transmit word |
| eng_push | input | 1 | Engine received one word |
| eng_rx_data | input | 32 | Received word |
| eng_frame_end | input | 1 | Frame-end pulse |
| eng_xfer_end | input | 1 | Transfer-end pulse |
| eng_busy | input | 1 | Engine busy level |
| irq | output | 1 | Level interrupt |

## Verification
A pointer or count that is wrong inside either FIFO appears in the FIFO-status word as soon as the next read is made. It also flips the watermark level bits, and through them the interrupt, in the same cycle. Lost or out-of-order words show up on `eng_tx_data` or on receive-data reads at the first pop after the fault. An event flag that clears itself, or that ignores its clearing write, appears in the status word and on `irq` one cycle after the pulse or the write.

// File: rtl/spi_fs_pkg.sv
package spi_fs_pkg;

    // register byte offsets
    localparam logic [5:0] A_PARAM  = 6'h00;
    localparam logic [5:0] A_CTRL   = 6'h04;
    localparam logic [5:0] A_STAT   = 6'h08;
    localparam logic [5:0] A_IEN    = 6'h0C;
    localparam logic [5:0] A_WMARK  = 6'h10;
    localparam logic [5:0] A_FSTAT  = 6'h14;
    localparam logic [5:0] A_TXDATA = 6'h18;
    localparam logic [5:0] A_RXSTAT = 6'h1C;
    localparam logic [5:0] A_RXDATA = 6'h20;

    // status / enable bit positions
    localparam int B_TXREQ = 0;
    localparam int B_RXRDY = 1;
    localparam int B_FRAME = 9;
    localparam int B_XFER  = 10;
    localparam int B_TXOVF = 11;
    localparam int B_RXUNF = 12;
    localparam int B_BUSY  = 24;

    localparam int EVT_LO = 9;
    localparam int EVT_N  = 4;

    localparam logic [31:0] IEN_KEEP = 32'h0000_1E03;

    // control bit positions
    localparam int C_EN    = 0;
    localparam int C_SRST  = 1;
    localparam int C_FLTX  = 8;
    localparam int C_FLRX  = 9;

    typedef enum logic [3:0] {
        SEL_PARAM,
        SEL_CTRL,
        SEL_STAT,
        SEL_IEN,
        SEL_WMARK,
        SEL_FSTAT,
        SEL_TXDATA,
        SEL_RXSTAT,
        SEL_RXDATA,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [5:0] a);
        reg_sel_e s;
        unique case (a)
            A_PARAM:  s = SEL_PARAM;
            A_CTRL:   s = SEL_CTRL;
            A_STAT:   s = SEL_STAT;
            A_IEN:    s = SEL_IEN;
            A_WMARK:  s = SEL_WMARK;
            A_FSTAT:  s = SEL_FSTAT;
            A_TXDATA: s = SEL_TXDATA;
            A_RXSTAT: s = SEL_RXSTAT;
            A_RXDATA: s = SEL_RXDATA;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sfs_fifo.sv
module sfs_fifo #(
    parameter int DW  = 32,
    parameter int AL2 = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           push,
    input  logic [DW-1:0]  din,
    input  logic           pop,
    output logic [DW-1:0]  dout,
    output logic [AL2:0]   count,
    output logic           full,
    output logic           empty
);
    localparam int DEPTH = 1 << AL2;
    localparam int CW    = AL2 + 1;

    logic [DW-1:0]  mem [DEPTH];
    logic [AL2-1:0] wr_ptr, rd_ptr;
    logic           push_ok, pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wr_ptr] <= din;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R3
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (full && $stable(wr_ptr))); // R3
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clr) |=> (empty && $stable(rd_ptr))); // R4
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty); // R10

endmodule

// File: rtl/sfs_flags.sv
module sfs_flags
    import spi_fs_pkg::*;
#(
    parameter int TXCW = 3,
    parameter int RXCW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [TXCW-1:0]  tx_count,
    input  logic [RXCW-1:0]  rx_count,
    input  logic [TXCW-1:0]  tx_wm,
    input  logic [RXCW-1:0]  rx_wm,
    input  logic [EVT_N-1:0] evt_set,
    input  logic             w1c_wr,
    input  logic [EVT_N-1:0] w1c_bits,
    input  logic             ien_wr,
    input  logic [31:0]      ien_wdata,
    input  logic             busy,
    output logic [31:0]      status,
    output logic [31:0]      ien,
    output logic             irq
);
    logic [EVT_N-1:0] evt_q;
    logic [EVT_N-1:0] evt_clr;

    assign evt_clr = w1c_wr ? w1c_bits : '0;

    // event flags: a new pulse wins over a clearing write in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            evt_q <= '0;
        end else begin
            for (int i = 0; i < EVT_N; i++) begin
                evt_q[i] <= evt_set[i] | (evt_q[i] & ~evt_clr[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ien <= '0;
        end else if (ien_wr) begin
            ien <= ien_wdata & IEN_KEEP;
        end
    end

    always_comb begin
        status                        = '0;
        status[B_TXREQ]               = (tx_count <= tx_wm);
        status[B_RXRDY]               = (rx_count > rx_wm);
        status[EVT_LO +: EVT_N]       = evt_q;
        status[B_BUSY]                = busy;
    end

    assign irq = |(status & ien);

    AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status[B_FRAME] && !clr && !(w1c_wr && w1c_bits[B_FRAME-EVT_LO]))
        |=> status[B_FRAME]); // R6
    AST_EVT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set[B_XFER-EVT_LO] && !clr) |=> status[B_XFER]); // R6
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_wr && w1c_bits[B_TXOVF-EVT_LO] && !evt_set[B_TXOVF-EVT_LO])
        |=> !status[B_TXOVF]); // R7

endmodule

// File: rtl/spi_fifo_stat.sv
module spi_fifo_stat
    import spi_fs_pkg::*;
#(
    parameter int DW      = 32,
    parameter int TX_AL2  = 2,
    parameter int RX_AL2  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [5:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic [DW-1:0] eng_tx_data,
    output logic          eng_tx_avail,
    input  logic          eng_pop,
    input  logic          eng_push,
    input  logic [DW-1:0] eng_rx_data,
    input  logic          eng_frame_end,
    input  logic          eng_xfer_end,
    input  logic          eng_busy,
    output logic          irq
);
    localparam int TXCW = TX_AL2 + 1;
    localparam int RXCW = RX_AL2 + 1;

    reg_sel_e          sel;
    logic              en_q;
    logic [TXCW-1:0]   tx_wm_q;
    logic [RXCW-1:0]   rx_wm_q;
    logic              wr_ctrl, srst, tx_clr, rx_clr;
    logic              tx_push, rx_pop;
    logic [DW-1:0]     rx_head;
    logic [TXCW-1:0]   tx_count;
    logic [RXCW-1:0]   rx_count;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [EVT_N-1:0]  evt_set;
    logic [31:0]       status, ien;
    logic              unused_bits;

    assign sel      = decode_sel(reg_addr);
    assign wr_ctrl  = reg_wr && (sel == SEL_CTRL);
    assign srst     = wr_ctrl && reg_wdata[C_SRST];
    assign tx_clr   = srst || (wr_ctrl && reg_wdata[C_FLTX]);
    assign rx_clr   = srst || (wr_ctrl && reg_wdata[C_FLRX]);
    assign tx_push  = reg_wr && (sel == SEL_TXDATA);
    assign rx_pop   = reg_rd && (sel == SEL_RXDATA);
    assign unused_bits = ^{rx_full, reg_wdata};

    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            en_q    <= 1'b0;
            tx_wm_q <= '0;
            rx_wm_q <= '0;
        end else begin
            if (wr_ctrl) en_q <= reg_wdata[C_EN];
            if (reg_wr && (sel == SEL_WMARK)) begin
                tx_wm_q <= reg_wdata[TXCW-1:0];
                rx_wm_q <= reg_wdata[16 +: RXCW];
            end
        end
    end

    sfs_fifo #(.DW(DW), .AL2(TX_AL2)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tx_clr),
        .push  (tx_push),
        .din   (reg_wdata[DW-1:0]),
        .pop   (eng_pop && en_q),
        .dout  (eng_tx_data),
        .count (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    sfs_fifo #(.DW(DW), .AL2(RX_AL2)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_clr),
        .push  (eng_push && en_q),
        .din   (eng_rx_data),
        .pop   (rx_pop),
        .dout  (rx_head),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign eng_tx_avail = !tx_empty;

    always_comb begin
        evt_set                  = '0;
        evt_set[B_FRAME-EVT_LO]  = eng_frame_end && en_q;
        evt_set[B_XFER-EVT_LO]   = eng_xfer_end && en_q;
        evt_set[B_TXOVF-EVT_LO]  = tx_push && tx_full;
        evt_set[B_RXUNF-EVT_LO]  = rx_pop && rx_empty;
    end

    sfs_flags #(.TXCW(TXCW), .RXCW(RXCW)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (srst),
        .tx_count  (tx_count),
        .rx_count  (rx_count),
        .tx_wm     (tx_wm_q),
        .rx_wm     (rx_wm_q),
        .evt_set   (evt_set),
        .w1c_wr    (reg_wr && (sel == SEL_STAT)),
        .w1c_bits  (reg_wdata[EVT_LO +: EVT_N]),
        .ien_wr    (reg_wr && (sel == SEL_IEN)),
        .ien_wdata (reg_wdata),
        .busy      (eng_busy),
        .status    (status),
        .ien       (ien),
        .irq       (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_PARAM:  begin
                reg_rdata[3:0]  = 4'(TX_AL2);
                reg_rdata[11:8] = 4'(RX_AL2);
            end
            SEL_CTRL:   reg_rdata[C_EN] = en_q;
            SEL_STAT:   reg_rdata = status;
            SEL_IEN:    reg_rdata = ien;
            SEL_WMARK:  begin
                reg_rdata[TXCW-1:0]    = tx_wm_q;
                reg_rdata[16 +: RXCW]  = rx_wm_q;
            end
            SEL_FSTAT:  begin
                reg_rdata[7:0]        = 8'(tx_count);
                reg_rdata[16 +: RXCW] = rx_count;
            end
            SEL_RXSTAT: reg_rdata[1] = rx_empty;
            SEL_RXDATA: reg_rdata[DW-1:0] = rx_head;
            SEL_TXDATA, SEL_NONE: reg_rdata = '0;
        endcase
    end

    AST_OFF_NO_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !tx_clr) |=> (tx_count >= $past(tx_count))); // R12
    AST_OFF_NO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !rx_clr && !rx_pop) |=> $stable(rx_count)); // R12
    AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!irq && !en_q)); // R11

endmodule

// File: tb/spi_fifo_stat_tb.sv
`timescale 1ns/1ps
module spi_fifo_stat_tb;

    localparam logic [2:0] OP_W = 3'd0, OP_R = 3'd1, OP_P = 3'd2, OP_Q = 3'd3,
                           OP_F = 3'd4, OP_X = 3'd5, OP_I = 3'd6;

    typedef struct packed {
        logic [2:0]  op;
        logic [5:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 63;
    localparam vec_t TBL [NV] = '{
        '{OP_R, 6'h00, 32'h0, 32'h0000_0202, 4'd1},  // R1 param
        '{OP_R, 6'h08, 32'h0, 32'h0000_0001, 4'd1},  // R1 status
        '{OP_R, 6'h14, 32'h0, 32'h0000_0000, 4'd1},  // R1 counts
        '{OP_I, 6'h00, 32'h0, 32'h0,         4'd1},  // R1 irq low
        '{OP_W, 6'h04, 32'h1, 32'h0,         4'd12}, // R12 enable
        '{OP_W, 6'h18, 32'hA1, 32'h0,        4'd2},  // R2
        '{OP_W, 6'h18, 32'hA2, 32'h0,        4'd2},
        '{OP_W, 6'h18, 32'hA3, 32'h0,        4'd2},
        '{OP_R, 6'h14, 32'h0, 32'h0000_0003, 4'd2},
        '{OP_R, 6'h08, 32'h0, 32'h0000_0000, 4'd5},  // R5 3 > wm 0
        '{OP_W, 6'h10, 32'h0001_0002, 32'h0, 4'd5},
        '{OP_R, 6'h10, 32'h0, 32'h0001_0002, 4'd5},
        '{OP_R, 6'h08, 32'h0, 32'h0000_0000, 4'd5},
        '{OP_P, 6'h00, 32'h0, 32'hA1,        4'd2},  // R2 order
        '{OP_R, 6'h08, 32'h0, 32'h0000_0001, 4'd5},
        '{OP_P, 6'h00, 32'h0, 32'hA2,        4'd2},
        '{OP_Q, 6'h00, 32'h11, 32'h0,        4'd2},
        '{OP_Q, 6'h00, 32'h22, 32'h0,        4'd2},
        '{OP_R, 6'h14, 32'h0, 32'h0002_0001, 4'd2},
        '{OP_R, 6'h08, 32'h0, 32'h0000_0003, 4'd5},
        '{OP_R, 6'h1C, 32'h0, 32'h0000_0000, 4'd4},  // R4
        '{OP_R, 6'h20, 32'h0, 32'h0000_0011, 4'd4},
        '{OP_R, 6'h20, 32'h0, 32'h0000_0022, 4'd4},
        '{OP_R, 6'h1C, 32'h0, 32'h0000_0002, 4'd4},
        '{OP_R, 6'h20, 32'h0, 32'h0000_0000, 4'd4},  // empty read
        '{OP_R, 6'h08, 32'h0, 32'h0000_1001, 4'd4},
        '{OP_R, 6'h14, 32'h0, 32'h0000_0001, 4'd4},
        '{OP_F, 6'h00, 32'h0, 32'h0,         4'd6},  // R6
        '{OP_R, 6'h08, 32'h0, 32'h0000_1201, 4'd6},
        '{OP_X, 6'h00, 32'h0, 32'h0,         4'd6},
        '{OP_R, 6'h08, 32'h0, 32'h0000_1601, 4'd6},
        '{OP_W, 6'h08, 32'h0, 32'h0,         4'd6},
        '{OP_R, 6'h08, 32'h0, 32'h0000_1601, 4'd6},
        '{OP_W, 6'h08, 32'h200, 32'h0,       4'd7},  // R7
        '{OP_R, 6'h08, 32'h0, 32'h0000_1401, 4'd7},
        '{OP_W, 6'h0C, 32'hFFFF_FFFF, 32'h0, 4'd9},  // R9
        '{OP_R, 6'h0C, 32'h0, 32'h0000_1E03, 4'd9},
        '{OP_W, 6'h0C, 32'h2, 32'h0,         4'd9},
        '{OP_I, 6'h00, 32'h0, 32'h0,         4'd9},
        '{OP_W, 6'h0C, 32'h400, 32'h0,       4'd9},
        '{OP_I, 6'h00, 32'h0, 32'h1,         4'd9},
        '{OP_W, 6'h08, 32'h3F00, 32'h0,      4'd7},
        '{OP_R, 6'h08, 32'h0, 32'h0000_0001, 4'd7},
        '{OP_I, 6'h00, 32'h0, 32'h0,         4'd9},
        '{OP_W, 6'h18, 32'hB1, 32'h0,        4'd3},  // R3
        '{OP_W, 6'h18, 32'hB2, 32'h0,        4'd3},
        '{OP_W, 6'h18, 32'hB3, 32'h0,        4'd3},
        '{OP_W, 6'h18, 32'hEE, 32'h0,        4'd3},  // overflow
        '{OP_R, 6'h14, 32'h0, 32'h0000_0004, 4'd3},
        '{OP_R, 6'h08, 32'h0, 32'h0000_0800, 4'd3},
        '{OP_P, 6'h00, 32'h0, 32'hA3,        4'd3},
        '{OP_P, 6'h00, 32'h0, 32'hB1,        4'd3},
        '{OP_P, 6'h00, 32'h0, 32'hB2,        4'd3},
        '{OP_P, 6'h00, 32'h0, 32'hB3,        4'd3},
        '{OP_R, 6'h14, 32'h0, 32'h0000_0000, 4'd3},
        '{OP_W, 6'h18, 32'h55, 32'h0,        4'd10}, // R10
        '{OP_Q, 6'h00, 32'h66, 32'h0,        4'd10},
        '{OP_R, 6'h14, 32'h0, 32'h0001_0001, 4'd10},
        '{OP_W, 6'h04, 32'h101, 32'h0,       4'd10},
        '{OP_R, 6'h14, 32'h0, 32'h0001_0000, 4'd10},
        '{OP_W, 6'h04, 32'h201, 32'h0,       4'd10},
        '{OP_R, 6'h14, 32'h0, 32'h0000_0000, 4'd10},
        '{OP_R, 6'h04, 32'h0, 32'h0000_0001, 4'd12}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] eng_tx_data;
    logic        eng_tx_avail;
    logic        eng_pop = 1'b0, eng_push = 1'b0;
    logic [31:0] eng_rx_data = '0;
    logic        eng_frame_end = 1'b0, eng_xfer_end = 1'b0, eng_busy = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    spi_fifo_stat u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .eng_tx_data   (eng_tx_data),
        .eng_tx_avail  (eng_tx_avail),
        .eng_pop       (eng_pop),
        .eng_push      (eng_push),
        .eng_rx_data   (eng_rx_data),
        .eng_frame_end (eng_frame_end),
        .eng_xfer_end  (eng_xfer_end),
        .eng_busy      (eng_busy),
        .irq           (irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle_inputs();
        reg_wr = 1'b0; reg_rd = 1'b0; eng_pop = 1'b0; eng_push = 1'b0;
        eng_frame_end = 1'b0; eng_xfer_end = 1'b0;
    endtask

    task automatic finish_cycle();
        @(posedge clk);
        #1 idle_inputs();
    endtask

    task automatic apply(input vec_t v);
        string tag;
        @(negedge clk);
        tag = $sformatf("R%0d addr %h", v.req, v.addr);
        reg_addr = v.addr;
        unique case (v.op)
            OP_W: begin reg_wr = 1'b1; reg_wdata = v.data; end
            OP_R: reg_rd = 1'b1;
            OP_P: eng_pop = 1'b1;
            OP_Q: begin eng_push = 1'b1; eng_rx_data = v.data; end
            OP_F: eng_frame_end = 1'b1;
            OP_X: eng_xfer_end = 1'b1;
            default: ;
        endcase
        #1;
        if (v.op == OP_R) check(tag, reg_rdata, v.exp);
        if (v.op == OP_P) check(tag, eng_tx_data, v.exp);
        if (v.op == OP_I) check(tag, {31'b0, irq}, v.exp);
        finish_cycle();
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        finish_cycle();
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 check(tag, reg_rdata, exp);
        finish_cycle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < NV; i++) apply(TBL[i]);

        // R8: busy mirror (bit 11 still set from the overflow)
        @(negedge clk); eng_busy = 1'b1;
        rd(6'h08, 32'h0100_0801, "R8 busy high");
        @(negedge clk); eng_busy = 1'b0;
        rd(6'h08, 32'h0000_0801, "R8 busy low");

        // R6: frame pulse in the same cycle as its clearing write
        @(negedge clk);
        reg_addr = 6'h08; reg_wdata = 32'h200; reg_wr = 1'b1; eng_frame_end = 1'b1;
        finish_cycle();
        rd(6'h08, 32'h0000_0A01, "R6 set wins over clear");

        // R2: receive word dropped when full
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); eng_push = 1'b1; eng_rx_data = 32'hC0 + k;
            finish_cycle();
        end
        rd(6'h14, 32'h0004_0000, "R2 rx count saturates");
        rd(6'h20, 32'h0000_00C0, "R2 rx oldest first");
        wr(6'h04, 32'h201);

        // R12: engine inputs ignored while disabled
        wr(6'h08, 32'h3F00);
        wr(6'h04, 32'h0);
        wr(6'h18, 32'h77);
        @(negedge clk);
        eng_pop = 1'b1; eng_push = 1'b1; eng_rx_data = 32'h99;
        eng_frame_end = 1'b1; eng_xfer_end = 1'b1;
        finish_cycle();
        rd(6'h14, 32'h0000_0001, "R12 counts frozen");
        rd(6'h08, 32'h0000_0001, "R12 no events");
        @(negedge clk); #1 check("R12 head kept", eng_tx_data, 32'h77);

        // R11: soft reset
        wr(6'h0C, 32'h1);
        @(negedge clk); #1 check("R11 irq before reset", {31'b0, irq}, 32'h1);
        wr(6'h04, 32'h3);
        rd(6'h04, 32'h0, "R11 ctrl");
        rd(6'h0C, 32'h0, "R11 ien");
        rd(6'h10, 32'h0, "R11 wmark");
        rd(6'h14, 32'h0, "R11 counts");
        rd(6'h08, 32'h1, "R11 status");
        @(negedge clk); #1 check("R11 irq", {31'b0, irq}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule